// File: doc/BRIEF.md
# Partial-Width Register Writeback Merge

This block is the write side of a sixteen-entry, 64-bit general register file. Each cycle it may accept one result together with a destination number, an operand size (8, 16, 32 or 64 bits), an explicit high-byte request and an instruction-wide flag saying that a register-extension prefix was present. It merges the result into the old register contents according to the size rules and stores the merged word on the next rising clock edge. A 32-bit write clears the upper half of the destination. Narrower writes keep every bit they do not cover.

Two read ports return one operand each, already cut to the operand size and zero-extended to 64 bits. The byte-register numbering is applied on the write port and on both read ports. Without the prefix, byte numbers 4 to 7 name bits 15:8 of registers 0 to 3. With the prefix, every byte number names the low byte of the register with that number. The block also flags any instruction that mixes a legacy high-byte operand with a new low-byte operand. A flagged instruction does not write.

Top module: `gprw_regfile`

## Requirements
- R1: Synchronous active-high reset clears all sixteen registers to zero, so every read returns 0 after reset.
- R2: A write of size code 2'b11 (64 bits) stores the whole result into the destination.
- R3: A write of size code 2'b10 (32 bits) stores result bits 31:0 and forces destination bits 63:32 to zero.
- R4: A write of size code 2'b01 (16 bits) stores result bits 15:0 and leaves destination bits 63:16 unchanged.
- R5: A write of size code 2'b00 (8 bits) to the low byte stores result bits 7:0 and leaves destination bits 63:8 unchanged.
- R6: At size code 2'b00 without the prefix, byte numbers 4 to 7 address bits 15:8 of registers 0 to 3, for writes and for reads. A write there stores result bits 7:0 into 15:8 and keeps bits 7:0 and 63:16.
- R7: At size code 2'b00 with the prefix, byte numbers 4 to 15 address bits 7:0 of the register with that number.
- R8: An operand's high-byte request, at size code 2'b00, addresses bits 15:8 of register number bits 1:0, whatever the prefix flag says. At any other size the request has no effect.
- R9: Each read port returns its operand zero-extended to 64 bits: bits 7:0 or 15:8 for a byte, 15:0, 31:0, or the whole register.
- R10: A read of the register being written in the same cycle returns the old contents. The new contents are visible from the cycle after the write.
- R11: The conflict output is high in the same cycle when an active operand is a legacy high byte (from R6 or R8) and another active operand is a new low byte (prefix present, 8-bit, number 4 or above, no high request). A legacy low byte paired with a new byte does not raise the flag. An active operand is the write port when write enable is high, or a read port when its use input is high.
- R12: While the conflict output is high, no register changes.
- R13: With write enable low, no register changes. A write changes only its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 4 | Destination register or byte number |
| wr_size | input | 2 | Write size: 00=8, 01=16, 10=32, 11=64 bits |
| wr_hi | input | 1 | Explicit high-byte request for the write |
| wr_data | input | 64 | Result value to merge |
| ext_present | input | 1 | Register-extension prefix present for the instruction |
| rd_a_use | input | 1 | Read port A belongs to the instruction (counts toward the conflict) |
| rd_a_idx | input | 4 | Read port A register or byte number |
| rd_a_size | input | 2 | Read port A size, same encoding as wr_size |
| rd_a_hi | input | 1 | Read port A explicit high-byte request |
| rd_a_data | output | 64 | Read port A operand, zero-extended |
| rd_b_use | input | 1 | Read port B belongs to the instruction |
| rd_b_idx | input | 4 | Read port B register or byte number |
| rd_b_size | input | 2 | Read port B size |
| rd_b_hi | input | 1 | Read port B explicit high-byte request |
| rd_b_data | output | 64 | Read port B operand, zero-extended |
| byte_conflict | output | 1 | Illegal mix of legacy high byte and new byte |

## Verification
Two things can happen in the same cycle. A write can target a register that a read port selects in that cycle, and a byte-register conflict can arise while a write is requested. The bench provokes the first case directly by reading the destination during its own write, and expects the old value then and the merged value one cycle later. It provokes the second by pairing a new-byte write with a legacy high-byte read, and expects the flag to be raised and every register to stay the same. A long random run mixes both cases with all sizes and both prefix states against a behavioural model that is compared every cycle.

// File: rtl/gprw_pkg.sv
package gprw_pkg;

    localparam int GPR_COUNT = 16;
    localparam int GPR_XLEN  = 64;
    localparam int GPR_IDXW  = $clog2(GPR_COUNT);

    // operand size encoding shared by the write port and both read ports
    typedef enum logic [1:0] {
        OPSZ_B = 2'b00,
        OPSZ_W = 2'b01,
        OPSZ_D = 2'b10,
        OPSZ_Q = 2'b11
    } opsz_e;

    // outcome of resolving one operand against the byte-register numbering
    typedef struct packed {
        logic [GPR_IDXW-1:0] phys;      // physical register touched
        logic                hi_lane;   // operand lives in bits 15:8
        logic                legacy_hi; // operand is a legacy high byte
        logic                new_byte;  // operand is a prefix-only low byte
    } opnd_sel_t;

    // first byte number that is remapped by the extension prefix
    localparam int REMAP_BASE = 4;

    function automatic logic is_remap_window(input logic [GPR_IDXW-1:0] idx);
        return (idx >= GPR_IDXW'(REMAP_BASE)) && (idx < GPR_IDXW'(2*REMAP_BASE));
    endfunction

endpackage

// File: rtl/gprw_opnd_decode.sv
module gprw_opnd_decode
    import gprw_pkg::*;
(
    input  logic [GPR_IDXW-1:0] idx,
    input  opsz_e               size,
    input  logic                hi_req,
    input  logic                ext,
    output opnd_sel_t           sel
);
    always_comb begin
        sel           = '0;
        sel.phys      = idx;
        if (size == OPSZ_B) begin
            if (hi_req) begin
                // explicit high byte: bits 15:8 of one of the first four registers
                sel.phys      = {{(GPR_IDXW-2){1'b0}}, idx[1:0]};
                sel.hi_lane   = 1'b1;
                sel.legacy_hi = 1'b1;
            end else if (!ext && is_remap_window(idx)) begin
                // legacy numbering without prefix
                sel.phys      = {{(GPR_IDXW-2){1'b0}}, idx[1:0]};
                sel.hi_lane   = 1'b1;
                sel.legacy_hi = 1'b1;
            end else if (ext && (idx >= GPR_IDXW'(REMAP_BASE))) begin
                sel.new_byte  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gprw_merge.sv
module gprw_merge
    import gprw_pkg::*;
#(
    parameter int XLEN = GPR_XLEN
) (
    input  logic [XLEN-1:0] old_word,
    input  logic [XLEN-1:0] result,
    input  opsz_e           size,
    input  logic            hi_lane,
    output logic [XLEN-1:0] new_word
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        new_word = old_word;
        unique case (size)
            OPSZ_B: begin
                if (hi_lane) new_word[15:8] = result[7:0];
                else         new_word[7:0]  = result[7:0];
            end
            OPSZ_W: new_word[15:0] = result[15:0];
            OPSZ_D: new_word = {{(XLEN-HALF){1'b0}}, result[HALF-1:0]};
            OPSZ_Q: new_word = result;
            default: new_word = old_word;
        endcase
    end
endmodule

// File: rtl/gprw_read_align.sv
module gprw_read_align
    import gprw_pkg::*;
#(
    parameter int XLEN = GPR_XLEN
) (
    input  logic [XLEN-1:0] word,
    input  opsz_e           size,
    input  logic            hi_lane,
    output logic [XLEN-1:0] operand
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        operand = '0;
        unique case (size)
            OPSZ_B: operand[7:0]      = hi_lane ? word[15:8] : word[7:0];
            OPSZ_W: operand[15:0]     = word[15:0];
            OPSZ_D: operand[HALF-1:0] = word[HALF-1:0];
            OPSZ_Q: operand           = word;
            default: operand          = '0;
        endcase
    end
endmodule

// File: rtl/gprw_regfile.sv
module gprw_regfile
    import gprw_pkg::*;
#(
    parameter int NREGS = GPR_COUNT,
    parameter int XLEN  = GPR_XLEN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [GPR_IDXW-1:0]   wr_idx,
    input  logic [1:0]            wr_size,
    input  logic                  wr_hi,
    input  logic [XLEN-1:0]       wr_data,
    input  logic                  ext_present,
    input  logic                  rd_a_use,
    input  logic [GPR_IDXW-1:0]   rd_a_idx,
    input  logic [1:0]            rd_a_size,
    input  logic                  rd_a_hi,
    output logic [XLEN-1:0]       rd_a_data,
    input  logic                  rd_b_use,
    input  logic [GPR_IDXW-1:0]   rd_b_idx,
    input  logic [1:0]            rd_b_size,
    input  logic                  rd_b_hi,
    output logic [XLEN-1:0]       rd_b_data,
    output logic                  byte_conflict
);
    localparam int HALF = XLEN / 2;
    localparam int NPORT = 3; // write, read A, read B

    logic [XLEN-1:0] gpr_q [NREGS];
    logic [NREGS*XLEN-1:0] gpr_flat;

    opsz_e     size_v [NPORT];
    opnd_sel_t sel_v  [NPORT];
    logic [GPR_IDXW-1:0] idx_v [NPORT];
    logic      hi_v   [NPORT];
    logic      act_v  [NPORT];

    assign size_v[0] = opsz_e'(wr_size);
    assign size_v[1] = opsz_e'(rd_a_size);
    assign size_v[2] = opsz_e'(rd_b_size);
    assign idx_v[0]  = wr_idx;
    assign idx_v[1]  = rd_a_idx;
    assign idx_v[2]  = rd_b_idx;
    assign hi_v[0]   = wr_hi;
    assign hi_v[1]   = rd_a_hi;
    assign hi_v[2]   = rd_b_hi;
    assign act_v[0]  = wr_en;
    assign act_v[1]  = rd_a_use;
    assign act_v[2]  = rd_b_use;

    // one decoder per operand slot
    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        gprw_opnd_decode u_dec (
            .idx    (idx_v[p]),
            .size   (size_v[p]),
            .hi_req (hi_v[p]),
            .ext    (ext_present),
            .sel    (sel_v[p])
        );
    end

    // conflict: any active legacy high byte together with any active new byte
    logic any_legacy, any_new;
    always_comb begin
        any_legacy = 1'b0;
        any_new    = 1'b0;
        for (int p = 0; p < NPORT; p++) begin
            any_legacy |= act_v[p] & sel_v[p].legacy_hi;
            any_new    |= act_v[p] & sel_v[p].new_byte;
        end
    end
    assign byte_conflict = any_legacy & any_new;

    // write path
    logic                commit;
    logic [GPR_IDXW-1:0] w_phys;
    logic [XLEN-1:0]     target_old, merged;

    assign commit     = wr_en & ~byte_conflict;
    assign w_phys     = sel_v[0].phys;
    assign target_old = gpr_q[w_phys];

    gprw_merge #(.XLEN(XLEN)) u_merge (
        .old_word (target_old),
        .result   (wr_data),
        .size     (size_v[0]),
        .hi_lane  (sel_v[0].hi_lane),
        .new_word (merged)
    );

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                         gpr_q[i] <= '0;
            else if (commit && (w_phys == GPR_IDXW'(i)))     gpr_q[i] <= merged;
        end
        assign gpr_flat[i*XLEN +: XLEN] = gpr_q[i];

        // R13: a register other than the committed destination holds its value
        a_r13_untouched_hold: assert property (@(posedge clk) disable iff (rst)
            !(commit && (w_phys == GPR_IDXW'(i))) |=> $stable(gpr_q[i]));
    end

    // read path
    gprw_read_align #(.XLEN(XLEN)) u_align_a (
        .word    (gpr_q[sel_v[1].phys]),
        .size    (size_v[1]),
        .hi_lane (sel_v[1].hi_lane),
        .operand (rd_a_data)
    );
    gprw_read_align #(.XLEN(XLEN)) u_align_b (
        .word    (gpr_q[sel_v[2].phys]),
        .size    (size_v[2]),
        .hi_lane (sel_v[2].hi_lane),
        .operand (rd_b_data)
    );

    // R3: a committed 32-bit write leaves the upper half zero
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (commit && size_v[0] == OPSZ_D) |=> (gpr_q[$past(w_phys)][XLEN-1:HALF] == '0));

    // R4: a committed 16-bit write keeps bits above 15
    a_r4_word_keeps_upper: assert property (@(posedge clk) disable iff (rst)
        (commit && size_v[0] == OPSZ_W) |=>
        (gpr_q[$past(w_phys)][XLEN-1:16] == $past(target_old[XLEN-1:16])));

    // R6: a committed high-lane byte write keeps the low byte and bits above 15
    a_r6_hilane_keeps_rest: assert property (@(posedge clk) disable iff (rst)
        (commit && size_v[0] == OPSZ_B && sel_v[0].hi_lane) |=>
        (gpr_q[$past(w_phys)][7:0] == $past(target_old[7:0]) &&
         gpr_q[$past(w_phys)][XLEN-1:16] == $past(target_old[XLEN-1:16])));

    // R12: a flagged instruction changes nothing in the file
    a_r12_conflict_no_write: assert property (@(posedge clk) disable iff (rst)
        byte_conflict |=> $stable(gpr_flat));

    // R7: a new byte operand can only arise with the prefix present
    a_r7_new_needs_prefix: assert property (@(posedge clk) disable iff (rst)
        (act_v[0] && sel_v[0].new_byte) |-> ext_present);

endmodule

// File: tb/gprw_regfile_bench.sv
module gprw_regfile_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_hi, ext_present;
    logic [3:0]  wr_idx;
    logic [1:0]  wr_size;
    logic [63:0] wr_data;
    logic        rd_a_use, rd_a_hi, rd_b_use, rd_b_hi;
    logic [3:0]  rd_a_idx, rd_b_idx;
    logic [1:0]  rd_a_size, rd_b_size;
    logic [63:0] rd_a_data, rd_b_data;
    logic        byte_conflict;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [63:0] m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    gprw_regfile u_gprw_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
        .wr_data(wr_data), .ext_present(ext_present),
        .rd_a_use(rd_a_use), .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size),
        .rd_a_hi(rd_a_hi), .rd_a_data(rd_a_data),
        .rd_b_use(rd_b_use), .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size),
        .rd_b_hi(rd_b_hi), .rd_b_data(rd_b_data),
        .byte_conflict(byte_conflict)
    );

    // ---------------- behavioural model ----------------
    function automatic int phys_of(logic [3:0] idx, logic [1:0] sz, logic hi, logic ext);
        if (sz == 2'b00 && hi) return idx % 4;
        if (sz == 2'b00 && !ext && idx >= 4 && idx <= 7) return idx - 4;
        return idx;
    endfunction

    function automatic bit high_of(logic [3:0] idx, logic [1:0] sz, logic hi, logic ext);
        return (sz == 2'b00) && (hi || (!ext && idx >= 4 && idx <= 7));
    endfunction

    function automatic bit newb_of(logic [3:0] idx, logic [1:0] sz, logic hi, logic ext);
        return (sz == 2'b00) && !hi && ext && idx >= 4;
    endfunction

    function automatic logic [63:0] ref_read(logic [3:0] idx, logic [1:0] sz, logic hi, logic ext);
        int p = phys_of(idx, sz, hi, ext);
        case (sz)
            2'b00:   return high_of(idx, sz, hi, ext) ? {56'd0, m[p][15:8]} : {56'd0, m[p][7:0]};
            2'b01:   return {48'd0, m[p][15:0]};
            2'b10:   return {32'd0, m[p][31:0]};
            default: return m[p];
        endcase
    endfunction

    function automatic bit ref_conflict();
        bit leg, nb;
        leg = (wr_en    && high_of(wr_idx,   wr_size,   wr_hi,   ext_present)) ||
              (rd_a_use && high_of(rd_a_idx, rd_a_size, rd_a_hi, ext_present)) ||
              (rd_b_use && high_of(rd_b_idx, rd_b_size, rd_b_hi, ext_present));
        nb  = (wr_en    && newb_of(wr_idx,   wr_size,   wr_hi,   ext_present)) ||
              (rd_a_use && newb_of(rd_a_idx, rd_a_size, rd_a_hi, ext_present)) ||
              (rd_b_use && newb_of(rd_b_idx, rd_b_size, rd_b_hi, ext_present));
        return leg && nb;
    endfunction

    task automatic model_write();
        int p;
        logic [63:0] v;
        if (!wr_en || ref_conflict()) return;
        p = phys_of(wr_idx, wr_size, wr_hi, ext_present);
        v = m[p];
        case (wr_size)
            2'b00: if (high_of(wr_idx, wr_size, wr_hi, ext_present)) v[15:8] = wr_data[7:0];
                   else v[7:0] = wr_data[7:0];
            2'b01: v[15:0] = wr_data[15:0];
            2'b10: v = {32'd0, wr_data[31:0]};
            default: v = wr_data;
        endcase
        m[p] = v;
    endtask

    // ---------------- checking ----------------
    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_ports(string tag);
        check64({tag, " port A"}, rd_a_data, ref_read(rd_a_idx, rd_a_size, rd_a_hi, ext_present));
        check64({tag, " port B"}, rd_b_data, ref_read(rd_b_idx, rd_b_size, rd_b_hi, ext_present));
        check64({tag, " conflict"}, {63'd0, byte_conflict}, {63'd0, ref_conflict()});
    endtask

    // ---------------- stimulus helpers (called at negedge) ----------------
    task automatic set_wr(logic en, logic [3:0] idx, logic [1:0] sz, logic hi, logic [63:0] d, logic ext);
        wr_en = en; wr_idx = idx; wr_size = sz; wr_hi = hi; wr_data = d; ext_present = ext;
    endtask

    task automatic set_rd(logic au, logic [3:0] ai, logic [1:0] as_, logic ah,
                          logic bu, logic [3:0] bi, logic [1:0] bs, logic bh);
        rd_a_use = au; rd_a_idx = ai; rd_a_size = as_; rd_a_hi = ah;
        rd_b_use = bu; rd_b_idx = bi; rd_b_size = bs; rd_b_hi = bh;
    endtask

    task automatic tick();
        @(posedge clk);
        model_write();
        @(negedge clk);
    endtask

    task automatic idle();
        set_wr(0, 0, 2'b11, 0, 64'd0, 0);
        set_rd(0, 0, 2'b11, 0, 0, 0, 2'b11, 0);
    endtask

    localparam logic [63:0] VA = 64'h0002_0001_8000_2201;
    localparam logic [63:0] VB = 64'h0002_0002_0123_3301;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] sum;
        for (int i = 0; i < 16; i++) m[i] = 64'd0;
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        set_rd(0, 4'd0, 2'b11, 0, 0, 4'd15, 2'b11, 0); #1;
        check64("R1 reg0 after reset", rd_a_data, 64'd0);
        check64("R1 reg15 after reset", rd_b_data, 64'd0);

        // R2 / R10: full write, same-cycle read shows old value
        set_wr(1, 4'd0, 2'b11, 0, VA, 0);
        set_rd(0, 4'd0, 2'b11, 0, 0, 4'd3, 2'b11, 0); #1;
        check64("R10 old value during write", rd_a_data, 64'd0);
        tick();
        set_wr(1, 4'd3, 2'b11, 0, VB, 0); #1;
        check64("R2 64-bit store / R10 next cycle", rd_a_data, VA);
        tick();
        idle(); set_rd(0, 4'd3, 2'b11, 0, 0, 4'd0, 2'b11, 0); #1;
        check_ports("R2 two registers");

        // R3: 32-bit add result zero-fills upper half
        sum = VA + VB;
        set_wr(1, 4'd3, 2'b10, 0, sum, 0); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0); #1;
        check64("R3 32-bit zero extension", rd_a_data, 64'h0000_0000_8123_5502);
        set_wr(1, 4'd3, 2'b11, 0, VB, 0); tick();

        // R4: 16-bit keeps upper
        set_wr(1, 4'd3, 2'b01, 0, sum, 0); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0); #1;
        check64("R4 16-bit preserve", rd_a_data, 64'h0002_0002_0123_5502);
        set_wr(1, 4'd3, 2'b11, 0, VB, 0); tick();

        // R5: 8-bit low byte
        set_wr(1, 4'd3, 2'b00, 0, 64'hFFFF_FFFF_FFFF_FF5A, 0); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0); #1;
        check64("R5 8-bit low preserve", rd_a_data, 64'h0002_0002_0123_335A);

        // R6: legacy numbering, byte 5 -> reg1 bits 15:8
        set_wr(1, 4'd1, 2'b11, 0, VA, 0); tick();
        set_wr(1, 4'd5, 2'b00, 0, 64'h0000_0000_0000_00C7, 0); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0);
        set_rd(0, 4'd1, 2'b11, 0, 0, 4'd5, 2'b00, 0); #1;
        check64("R6 high byte write", rd_a_data, 64'h0002_0001_8000_C701);
        check64("R6 high byte read", rd_b_data, 64'h0000_0000_0000_00C7);

        // R7: prefix numbering, byte 5 -> reg5 low byte, byte 12 -> reg12
        set_wr(1, 4'd5, 2'b00, 0, 64'h0000_0000_0000_0033, 1); tick();
        set_wr(1, 4'd12, 2'b00, 0, 64'h0000_0000_0000_0044, 1); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 1);
        set_rd(0, 4'd5, 2'b11, 0, 0, 4'd12, 2'b11, 0); #1;
        check64("R7 reg5 low byte", rd_a_data, 64'h0000_0000_0000_0033);
        check64("R7 reg12 low byte", rd_b_data, 64'h0000_0000_0000_0044);
        set_rd(0, 4'd1, 2'b11, 0, 0, 4'd5, 2'b00, 0); #1;
        check64("R7 reg1 untouched by prefixed byte 5", rd_a_data, 64'h0002_0001_8000_C701);

        // R8: explicit high request; ignored at 16 bits
        set_wr(1, 4'd14, 2'b00, 1, 64'h0000_0000_0000_0099, 1); tick();
        set_wr(1, 4'd2, 2'b01, 1, 64'h0000_0000_0000_BEEF, 0); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0);
        set_rd(0, 4'd2, 2'b11, 0, 0, 4'd14, 2'b11, 0); #1;
        check64("R8 high request at 16 bits ignored", rd_a_data, 64'h0000_0000_0000_BEEF);
        check64("R8 reg14 untouched", rd_b_data, 64'd0);
        set_wr(1, 4'd14, 2'b00, 1, 64'h0000_0000_0000_0099, 1); tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0); #1;
        check64("R8 high request byte 14 -> reg2[15:8]", rd_a_data, 64'h0000_0000_0000_99EF);

        // R9: zero extension on reads of every size
        set_rd(0, 4'd0, 2'b00, 0, 0, 4'd0, 2'b10, 0); #1;
        check64("R9 byte read", rd_a_data, 64'h01);
        check64("R9 dword read", rd_b_data, 64'h8000_2201);

        // R11 / R12: conflict flags and blocks the write
        set_wr(1, 4'd6, 2'b00, 0, 64'h0000_0000_0000_00EE, 1);
        set_rd(1, 4'd0, 2'b00, 1, 0, 4'd6, 2'b11, 0); #1;
        check64("R11 high+new conflict", {63'd0, byte_conflict}, 64'd1);
        tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0);
        set_rd(0, 4'd6, 2'b11, 0, 0, 4'd0, 2'b11, 0); #1;
        check64("R12 blocked write reg6", rd_a_data, 64'd0);
        check64("R12 reg0 unchanged", rd_b_data, VA);
        set_wr(1, 4'd6, 2'b00, 0, 64'h0000_0000_0000_00EE, 1);
        set_rd(1, 4'd0, 2'b00, 0, 1, 4'd3, 2'b00, 0); #1;
        check64("R11 legacy low + new allowed", {63'd0, byte_conflict}, 64'd0);
        tick();
        set_wr(0, 4'd0, 2'b11, 0, 64'd0, 0);
        set_rd(0, 4'd6, 2'b11, 0, 0, 4'd0, 2'b11, 0); #1;
        check64("R11 allowed write lands", rd_a_data, 64'h0000_0000_0000_00EE);

        // R13: disabled write changes nothing
        set_wr(0, 4'd0, 2'b11, 0, 64'hDEAD_BEEF_DEAD_BEEF, 0); tick(); #1;
        check64("R13 disabled write", rd_b_data, VA);

        // random mix, compared every cycle (R9 reads, R11 flag, R10 ordering)
        for (int k = 0; k < 4000; k++) begin
            set_wr($urandom_range(0, 3) != 0, 4'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0),
                   {$urandom, $urandom}, 1'($urandom));
            set_rd(1'($urandom), 4'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0),
                   1'($urandom), 4'($urandom), 2'($urandom), ($urandom_range(0, 7) == 0));
            #1;
            check_ports("R9 random");
            tick();
        end
        idle();
        for (int i = 0; i < 16; i++) begin
            set_rd(0, 4'(i), 2'b11, 0, 0, 4'(i), 2'b10, 0); #1;
            check_ports("R13 final contents");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule